// File: doc/BRIEF.md
# BSSID Mask Receive Address Filter

This block decides whether the BSSID carried by a received frame belongs to one of the networks the station hosts. It does not compare the frame against a list. It compares it against the station's own 48-bit address under a programmable mask. Mask bits set to one are compared and mask bits set to zero are ignored. A frame is accepted, which makes it eligible for acknowledgement, when every compared bit agrees. The mask is computed elsewhere and only needs to be loaded here. As a result, a foreign BSSID that agrees on every compared bit is accepted on purpose.

Software loads the station address and the mask through a small write port of 32-bit words with byte enables. A combinational read port returns the four registers. A frame BSSID is presented with a valid strobe. The decision appears one clock later on a registered accept flag, together with its own valid.

Top module: `bssid_accept_filter`

## Requirements
- R1: After reset, the mask is all ones, the own address and the control bits are zero, and `match_valid` and `match_accept` are low.
- R2: A frame is accepted exactly when (BSSID AND mask) equals (own address AND mask).
- R3: A mask bit of 0 excludes that address bit from the compare. With an all-ones mask, only a BSSID identical to the own address is accepted.
- R4: Register 2 holds mask bits 31:0. Register 3 bits 15:0 hold mask bits 47:32, and bits 31:16 of register 3 read as zero.
- R5: Register 0 holds own-address bits 31:0, and register 1 bits 15:0 hold own-address bits 47:32. A write applies only to the bytes whose `reg_be` bit is set, so a write with `reg_be`=0011 to register 1 leaves bits 31:16 of that register unchanged.
- R6: Address bytes are packed little-endian: the first transmitted address byte sits in bits 7:0 of register 0 and in bits 7:0 of `bssid`.
- R7: A BSSID that differs from the own address only in masked-out bits is accepted.
- R8: With own address 0x1 and mask 0x2, BSSID 0x6 is rejected, and 0x1, 0x4, 0x9 and 0xD are accepted.
- R9: `match_valid` is high exactly one clock after `bssid_valid`, and `match_accept` is low whenever `match_valid` is low. The decision uses the register contents held before any write made in the same cycle.
- R10: Bits 31:16 of register 1 are general control bits that read back exactly what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register selected for writing (0 own low, 1 own high/control, 2 mask low, 3 mask high) |
| reg_be | input | 4 | Byte enables for the write |
| reg_wdata | input | 32 | Write data |
| reg_rsel | input | 2 | Register selected for reading |
| reg_rdata | output | 32 | Read data for `reg_rsel` |
| bssid_valid | input | 1 | Frame BSSID strobe |
| bssid | input | 48 | Frame BSSID, first byte in bits 7:0 |
| match_valid | output | 1 | Decision valid, one clock after `bssid_valid` |
| match_accept | output | 1 | Frame accepted |

## Verification
The hardest situation to reach is a frame decided in the same cycle that a byte-enabled write changes the mask or the address. A missed byte lane or a bypass of the new value only shows up there. The stimulus therefore issues register writes with partial byte enables while frames stream through back to back. A behavioural model compares every cycle's decision, valid and read-back word, and the 4-bit case and the intended false accepts are driven as directed patterns.

// File: rtl/bssid_accept_filter.sv
module bssid_accept_filter #(
  parameter int ADDR_W = 48,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_sel,
  input  logic [WORD_W/8-1:0] reg_be,
  input  logic [WORD_W-1:0] reg_wdata,
  input  logic [1:0]        reg_rsel,
  output logic [WORD_W-1:0] reg_rdata,
  input  logic              bssid_valid,
  input  logic [ADDR_W-1:0] bssid,
  output logic              match_valid,
  output logic              match_accept
);
  localparam int HI_W = ADDR_W - WORD_W;
  localparam int BE_W = WORD_W / 8;
  localparam logic [1:0] SEL_OWN_LO  = 2'd0;
  localparam logic [1:0] SEL_OWN_HI  = 2'd1;
  localparam logic [1:0] SEL_MASK_LO = 2'd2;
  localparam logic [1:0] SEL_MASK_HI = 2'd3;

  logic [WORD_W-1:0] own_lo, own_hi, mask_lo;
  logic [HI_W-1:0]   mask_hi;
  logic [ADDR_W-1:0] own_addr, cmp_mask;
  logic [WORD_W-1:0] mask_hi_word;

  function automatic logic [WORD_W-1:0] merge(input logic [WORD_W-1:0] old_v,
                                               input logic [WORD_W-1:0] new_v,
                                               input logic [BE_W-1:0]   be);
    logic [WORD_W-1:0] r;
    r = old_v;
    for (int b = 0; b < BE_W; b++)
      if (be[b]) r[b*8 +: 8] = new_v[b*8 +: 8];
    return r;
  endfunction

  assign mask_hi_word = {{(WORD_W-HI_W){1'b0}}, mask_hi};
  assign own_addr     = {own_hi[HI_W-1:0], own_lo};
  assign cmp_mask     = {mask_hi, mask_lo};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      own_lo  <= '0;
      own_hi  <= '0;
      mask_lo <= '1;
      mask_hi <= '1;
    end else if (reg_we) begin
      case (reg_sel)
        SEL_OWN_LO:  own_lo  <= merge(own_lo, reg_wdata, reg_be);
        SEL_OWN_HI:  own_hi  <= merge(own_hi, reg_wdata, reg_be);
        SEL_MASK_LO: mask_lo <= merge(mask_lo, reg_wdata, reg_be);
        default: begin
          logic [WORD_W-1:0] mw;
          mw = merge(mask_hi_word, reg_wdata, reg_be);
          mask_hi <= mw[HI_W-1:0];
        end
      endcase
    end
  end

  always_comb begin
    case (reg_rsel)
      SEL_OWN_LO:  reg_rdata = own_lo;
      SEL_OWN_HI:  reg_rdata = own_hi;
      SEL_MASK_LO: reg_rdata = mask_lo;
      default:     reg_rdata = mask_hi_word;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      match_valid  <= 1'b0;
      match_accept <= 1'b0;
    end else begin
      match_valid  <= bssid_valid;
      match_accept <= bssid_valid && (((bssid ^ own_addr) & cmp_mask) == '0);
    end
  end
endmodule

// File: rtl/bssid_accept_filter_chk.sv
module bssid_accept_filter_chk #(
  parameter int ADDR_W = 48
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bssid_valid,
  input logic [ADDR_W-1:0] bssid,
  input logic              match_valid,
  input logic              match_accept,
  input logic [ADDR_W-1:0] own_addr,
  input logic [ADDR_W-1:0] cmp_mask
);
  a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    bssid_valid |=> match_valid);
  a_r9_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !bssid_valid |=> !match_valid);
  a_r9_accept_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !match_valid |-> !match_accept);
  a_r2_identical_accepted: assert property (@(posedge clk) disable iff (!rst_n)
    (bssid_valid && bssid == own_addr) |=> match_accept);
  a_r3_full_mask_exact: assert property (@(posedge clk) disable iff (!rst_n)
    (bssid_valid && &cmp_mask && bssid != own_addr) |=> !match_accept);
  a_r7_empty_mask_accepts: assert property (@(posedge clk) disable iff (!rst_n)
    (bssid_valid && cmp_mask == '0) |=> match_accept);
endmodule

bind bssid_accept_filter bssid_accept_filter_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bssid_valid(bssid_valid), .bssid(bssid),
  .match_valid(match_valid), .match_accept(match_accept),
  .own_addr(own_addr), .cmp_mask(cmp_mask)
);

// File: tb/bssid_accept_filter_test.sv
`timescale 1ns/1ps
module bssid_accept_filter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = '0;
  logic [3:0]  reg_be = '0;
  logic [31:0] reg_wdata = '0;
  logic [1:0]  reg_rsel = '0;
  logic [31:0] reg_rdata;
  logic        bssid_valid = 1'b0;
  logic [47:0] bssid = '0;
  logic        match_valid, match_accept;

  int checks = 0, errors = 0;
  bit done = 0;
  string cur_req = "R2";

  logic [47:0] m_own, m_mask;
  logic [15:0] m_ctrl;
  logic        e_valid, e_accept;

  always #4 clk = ~clk;

  bssid_accept_filter uut (.*);

  function automatic bit model_accept(input logic [47:0] f, input logic [47:0] o,
                                      input logic [47:0] m);
    for (int i = 0; i < 48; i++)
      if (m[i] && (f[i] != o[i])) return 0;
    return 1;
  endfunction

  function automatic logic [31:0] model_read(input logic [1:0] s);
    case (s)
      2'd0: return m_own[31:0];
      2'd1: return {m_ctrl, m_own[47:32]};
      2'd2: return m_mask[31:0];
      default: return {16'h0, m_mask[47:32]};
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_own <= '0; m_mask <= '1; m_ctrl <= '0;
      e_valid <= 0; e_accept <= 0;
    end else begin
      logic [31:0] w;
      e_valid  <= bssid_valid;
      e_accept <= bssid_valid && model_accept(bssid, m_own, m_mask);
      if (reg_we) begin
        w = model_read(reg_sel);
        for (int b = 0; b < 4; b++) if (reg_be[b]) w[b*8 +: 8] = reg_wdata[b*8 +: 8];
        case (reg_sel)
          2'd0: m_own[31:0] <= w;
          2'd1: begin m_own[47:32] <= w[15:0]; m_ctrl <= w[31:16]; end
          2'd2: m_mask[31:0] <= w;
          default: m_mask[47:32] <= w[15:0];
        endcase
      end
    end
  end

  task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    check("R9", {47'b0, match_valid}, {47'b0, e_valid});
    check(cur_req, {47'b0, match_accept}, {47'b0, e_accept});
    check(reg_rsel < 2 ? "R5" : "R4", {16'b0, reg_rdata}, {16'b0, model_read(reg_rsel)});
  end

  task automatic tick();
    @(negedge clk); #1;
    reg_we = 0; bssid_valid = 0;
    reg_rsel = reg_rsel + 2'd1;
  endtask

  task automatic wr(input logic [1:0] s, input logic [3:0] be, input logic [31:0] d);
    reg_we = 1; reg_sel = s; reg_be = be; reg_wdata = d;
    tick();
  endtask

  task automatic frame(input logic [47:0] f);
    bssid_valid = 1; bssid = f;
    tick();
  endtask

  task automatic frame_dir(input string req, input logic [47:0] f, input bit exp);
    bssid_valid = 1; bssid = f;
    @(negedge clk); #1; bssid_valid = 0;
    check(req, {47'b0, match_accept}, {47'b0, exp});
  endtask

  task automatic rd_dir(input string req, input logic [1:0] s, input logic [31:0] exp);
    logic [1:0] keep;
    keep = reg_rsel; reg_rsel = s; #1;
    check(req, {16'b0, reg_rdata}, {16'b0, exp});
    reg_rsel = keep;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    // R1 reset state
    check("R1", {47'b0, match_valid}, 48'd0);
    check("R1", {47'b0, match_accept}, 48'd0);
    rd_dir("R1", 2'd0, 32'h0);
    rd_dir("R1", 2'd1, 32'h0);
    rd_dir("R1", 2'd2, 32'hFFFF_FFFF);
    rd_dir("R1", 2'd3, 32'h0000_FFFF);
    tick();

    // R3 full mask: exact compare only
    cur_req = "R3";
    wr(2'd0, 4'hF, 32'h3322_1102);
    wr(2'd1, 4'h3, 32'hDEAD_5544);
    rd_dir("R6", 2'd0, 32'h3322_1102);
    rd_dir("R5", 2'd1, 32'h0000_5544);
    frame_dir("R3", 48'h5544_3322_1102, 1);
    frame_dir("R3", 48'h5544_3322_1103, 0);
    frame_dir("R6", 48'h0211_2233_4455, 0);

    // R10 control bits, R5 byte enables preserve them
    cur_req = "R10";
    wr(2'd1, 4'hC, 32'hA5C3_0000);
    rd_dir("R10", 2'd1, 32'hA5C3_5544);
    wr(2'd1, 4'h3, 32'h0000_6677);
    rd_dir("R5", 2'd1, 32'hA5C3_6677);
    wr(2'd3, 4'hF, 32'hFFFF_1234);
    rd_dir("R4", 2'd3, 32'h0000_1234);

    // R8 4-bit case
    cur_req = "R8";
    wr(2'd0, 4'hF, 32'h1);
    wr(2'd1, 4'h3, 32'h0);
    wr(2'd2, 4'hF, 32'h2);
    wr(2'd3, 4'hF, 32'h0);
    frame_dir("R8", 48'h6, 0);
    frame_dir("R8", 48'h1, 1);
    frame_dir("R8", 48'h4, 1);
    frame_dir("R8", 48'h9, 1);
    frame_dir("R8", 48'hD, 1);

    // R7 intended false accept in upper bits
    cur_req = "R7";
    wr(2'd2, 4'hF, 32'hFFFF_FFFF);
    frame_dir("R7", 48'hBEEF_0000_0001, 1);
    frame_dir("R7", 48'hBEEF_0000_0003, 0);

    // R2/R9 streaming frames with concurrent partial writes
    cur_req = "R2";
    for (int i = 0; i < 400; i++) begin
      logic [47:0] f;
      f = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
      if (i % 3 == 0) f = {m_own[47:8], f[7:0]};
      bssid_valid = (i % 5) != 4;
      bssid = f;
      if (i % 4 == 1) begin
        reg_we = 1; reg_sel = 2'($urandom); reg_be = 4'($urandom); reg_wdata = $urandom;
      end
      tick();
    end
    repeat (2) tick();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1600000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule